// File: doc/BRIEF.md
# FIR Multiply-Accumulate Sequencer

This block computes one output of a finite impulse response filter for every input sample it accepts. A sample offered on an idle cycle goes into an internal ring of the most recent `NumTaps` samples, the ring's write pointer moves on, and the accumulator is cleared. The block then runs a tap loop that takes one clock per tap. In each tap cycle it presents a coefficient address to an external coefficient memory and reads the matching delayed sample from the ring in the same clock. It multiplies the two values, adds the product into a wide accumulator, and moves both pointers.

Data and coefficients are signed Q15. Products are summed at full precision in an accumulator with guard bits, so no rounding happens during the loop. Rounding and saturation to 16 bits take place once, when the result is moved into the output holding register. The result is then announced by a single-cycle valid pulse. A sample that arrives while a computation is still in progress is dropped and flagged.

Top module: `fir_mac_seq`

## Requirements
- R1: After reset `busy`, `outValid`, `overrun` and `outData` are 0, and every stored past sample reads as zero in later results.
- R2: A `sampleValid` seen on a rising edge while `busy` is low is accepted. `busy` is then high for exactly `NumTaps`+1 cycles.
- R3: The result equals the sum over k = 0..NumTaps-1 of coef[k]·x[n-k]. Here x[n] is the sample just accepted and coef[k] is the coefficient memory word at address k. Ring slots that have never been written count as zero.
- R4: If a sample is accepted at rising edge t, `outValid` is high for exactly one cycle, the one that follows edge t+NumTaps+1.
- R5: In the cycle after the accepting edge, `coefAddr` is 0. It then rises by one per clock up to NumTaps-1.
- R6: The output is the sum shifted right by 15 after adding 2^14, so an exact half rounds toward positive infinity. For example, a sum of 16384 gives 1 and a sum of -16384 gives 0.
- R7: A rounded value above 32767 is output as 32767, and one below -32768 is output as -32768.
- R8: A `sampleValid` seen on an edge while `busy` is high sets `overrun` high for the next cycle only. The sample is discarded and never appears in any later result.
- R9: `outData` holds its value between result pulses.
- R10: Once more than NumTaps samples have been accepted, the oldest sample leaves the ring and no longer contributes to results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | New input sample offered |
| sampleIn | input | DataW | Signed Q15 input sample |
| coefAddr | output | $clog2(NumTaps) | Coefficient memory read address |
| coefData | input | DataW | Signed Q15 coefficient read in the same cycle |
| busy | output | 1 | Computation in progress |
| outValid | output | 1 | One-cycle result strobe |
| outData | output | DataW | Rounded and saturated result |
| overrun | output | 1 | One-cycle flag for a dropped sample |

## Verification
The bench counts edges from the edge that accepts a sample. `busy` and `coefAddr`=0 are expected right after that edge. `coefAddr` is expected to step by one on each of the next NumTaps-1 edges. `outValid` and the new `outData` are due after edge t+NumTaps+1, and `outValid` must be low again one edge later. All of these are sampled on the falling edge. An `overrun` caused by a sample offered during the loop is checked after the very next edge, and the dropped value is checked indirectly: it must stay out of a reference ring model that every later result is compared against.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;
  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;   // accept sample: write ring, clear accumulator
    logic tap;    // multiply-accumulate one tap
    logic store;  // round, saturate, move to output register
  } firCtrlT;

  typedef enum logic [1:0] {
    StIdle  = 2'd0,
    StRun   = 2'd1,
    StStore = 2'd2
  } firStateT;
endpackage

// File: rtl/fir_ctrl.sv
module fir_ctrl
  import fir_mac_pkg::*;
#(
  parameter int NumTaps = 16,
  parameter int AddrW   = $clog2(NumTaps)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  output firCtrlT          ctrl,
  output logic [AddrW-1:0] tapIdx,
  output logic             busy,
  output logic             overrun
);
  localparam logic [AddrW-1:0] LastTap = AddrW'(NumTaps - 1);

  firStateT state;

  always_comb begin
    ctrl.load  = sampleValid && (state == StIdle);
    ctrl.tap   = (state == StRun);
    ctrl.store = (state == StStore);
  end

  assign busy = (state != StIdle);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= StIdle;
      tapIdx  <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= sampleValid && (state != StIdle);
      unique case (state)
        StIdle: begin
          if (sampleValid) begin
            state  <= StRun;
            tapIdx <= '0;
          end
        end
        StRun: begin
          if (tapIdx == LastTap) state <= StStore;
          else                   tapIdx <= tapIdx + 1'b1;
        end
        StStore: state <= StIdle;
        default: state <= StIdle;
      endcase
    end
  end
endmodule

// File: rtl/fir_datapath.sv
module fir_datapath
  import fir_mac_pkg::*;
#(
  parameter int NumTaps = 16,
  parameter int DataW   = 16,
  parameter int AccW    = 40,
  parameter int AddrW   = $clog2(NumTaps)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  firCtrlT                 ctrl,
  input  logic signed [DataW-1:0] sampleIn,
  input  logic signed [DataW-1:0] coefData,
  output logic                    outValid,
  output logic signed [DataW-1:0] outData
);
  localparam int ProdW    = 2 * DataW;
  localparam int FracBits = DataW - 1;
  localparam logic [AddrW-1:0] LastSlot = AddrW'(NumTaps - 1);
  localparam logic signed [AccW-1:0] HalfLsb = AccW'(1) <<< (FracBits - 1);
  localparam logic signed [AccW-1:0] MaxOut  = AccW'((1 << (DataW - 1)) - 1);
  localparam logic signed [AccW-1:0] MinOut  = -(AccW'(1) <<< (DataW - 1));

  logic [AddrW-1:0]        wrPtr;
  logic [AddrW-1:0]        rdPtr;
  logic signed [AccW-1:0]  acc;
  logic signed [DataW-1:0] ring [NumTaps];
  logic signed [DataW-1:0] tapSample;
  logic signed [ProdW-1:0] prod;
  logic signed [AccW-1:0]  prodExt;
  logic signed [AccW-1:0]  rounded;
  logic signed [DataW-1:0] satOut;

  // One register per ring slot, written only on its own address
  for (genvar g = 0; g < NumTaps; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN)                                  ring[g] <= '0;
      else if (ctrl.load && wrPtr == AddrW'(g))   ring[g] <= sampleIn;
    end
  end

  always_comb begin
    tapSample = ring[rdPtr];
    prod      = tapSample * coefData;
    prodExt   = {{(AccW - ProdW){prod[ProdW-1]}}, prod};
    rounded   = (acc + HalfLsb) >>> FracBits;
    if (rounded > MaxOut)      satOut = MaxOut[DataW-1:0];
    else if (rounded < MinOut) satOut = MinOut[DataW-1:0];
    else                       satOut = rounded[DataW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      acc      <= '0;
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= ctrl.store;
      if (ctrl.load) begin
        rdPtr <= wrPtr;
        wrPtr <= (wrPtr == LastSlot) ? '0 : wrPtr + 1'b1;
        acc   <= '0;
      end else if (ctrl.tap) begin
        acc   <= acc + prodExt;
        rdPtr <= (rdPtr == '0) ? LastSlot : rdPtr - 1'b1;
      end
      if (ctrl.store) outData <= satOut;
    end
  end
endmodule

// File: rtl/fir_mac_seq.sv
module fir_mac_seq
  import fir_mac_pkg::*;
#(
  parameter int NumTaps = 16,
  parameter int DataW   = 16,
  parameter int AccW    = 40,
  localparam int AddrW  = $clog2(NumTaps)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sampleValid,
  input  logic signed [DataW-1:0] sampleIn,
  output logic [AddrW-1:0]        coefAddr,
  input  logic signed [DataW-1:0] coefData,
  output logic                    busy,
  output logic                    outValid,
  output logic signed [DataW-1:0] outData,
  output logic                    overrun
);
  firCtrlT ctrl;

  fir_ctrl #(.NumTaps(NumTaps), .AddrW(AddrW)) ctrl_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
    .ctrl(ctrl), .tapIdx(coefAddr), .busy(busy), .overrun(overrun)
  );

  fir_datapath #(.NumTaps(NumTaps), .DataW(DataW), .AccW(AccW), .AddrW(AddrW)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .sampleIn(sampleIn),
    .coefData(coefData), .outValid(outValid), .outData(outData)
  );
endmodule

// File: rtl/fir_mac_seq_chk.sv
module fir_mac_seq_chk #(
  parameter int NumTaps = 16,
  parameter int DataW   = 16,
  localparam int AddrW  = $clog2(NumTaps)
) (
  input logic             clk,
  input logic             rstN,
  input logic             sampleValid,
  input logic [AddrW-1:0] coefAddr,
  input logic             busy,
  input logic             outValid,
  input logic [DataW-1:0] outData,
  input logic             overrun
);
  logic [AddrW+1:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN)     busyCnt <= '0;
    else if (busy) busyCnt <= busyCnt + 1'b1;
    else           busyCnt <= '0;
  end

  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !busy) |=> busy);

  a_r2_busy_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyCnt == (AddrW+2)'(NumTaps + 1)));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  a_r4_pulse_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> outValid);

  a_r5_first_addr: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (coefAddr == '0));

  a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && busy) |=> overrun);

  a_r8_overrun_clear: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleValid && busy) |=> !overrun);

  a_r9_hold_output: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outData));
endmodule

bind fir_mac_seq fir_mac_seq_chk #(.NumTaps(NumTaps), .DataW(DataW)) chk_i (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .coefAddr(coefAddr),
  .busy(busy), .outValid(outValid), .outData(outData), .overrun(overrun)
);

// File: tb/fir_mac_seq_tb_top.sv
module fir_mac_seq_tb_top;
  localparam int NumTaps = 16;
  localparam int DataW   = 16;
  localparam int AddrW   = $clog2(NumTaps);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic signed [DataW-1:0] sampleIn = '0;
  logic [AddrW-1:0] coefAddr;
  logic signed [DataW-1:0] coefData;
  logic busy, outValid, overrun;
  logic signed [DataW-1:0] outData;

  logic signed [DataW-1:0] coefRom [NumTaps];
  logic signed [DataW-1:0] hist [NumTaps];
  int checks = 0;
  int fails = 0;
  bit doneFlag = 1'b0;

  always #5 clk = ~clk;

  assign coefData = coefRom[coefAddr];

  fir_mac_seq #(.NumTaps(NumTaps), .DataW(DataW)) dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .coefAddr(coefAddr), .coefData(coefData), .busy(busy),
    .outValid(outValid), .outData(outData), .overrun(overrun)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference result: full-precision sum, round half up, saturate
  function automatic longint refOut();
    longint s = 0;
    for (int k = 0; k < NumTaps; k++) s += longint'(coefRom[k]) * longint'(hist[k]);
    s = (s + 16384) >>> 15;
    if (s > 32767)  s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  task automatic sendSample(input logic signed [DataW-1:0] x, input bit injectOverrun);
    longint expOut;
    longint prevOut;
    while (busy) @(negedge clk);
    sampleValid = 1'b1;
    sampleIn    = x;
    @(posedge clk);
    @(negedge clk);
    sampleValid = 1'b0;
    for (int k = NumTaps - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    expOut = refOut();
    chk("R2 busy after accept", busy, 1);
    chk("R5 coefAddr first", coefAddr, 0);
    for (int k = 1; k < NumTaps; k++) begin
      if (injectOverrun && k == 3) begin
        sampleValid = 1'b1;
        sampleIn    = 16'sh1234;
      end
      @(posedge clk);
      @(negedge clk);
      if (injectOverrun && k == 3) begin
        chk("R8 overrun flagged", overrun, 1);
        sampleValid = 1'b0;
      end
      if (injectOverrun && k == 4) chk("R8 overrun one cycle", overrun, 0);
      chk("R5 coefAddr step", coefAddr, k);
      chk("R4 no early valid", outValid, 0);
    end
    @(posedge clk);
    @(negedge clk);
    chk("R2 busy in store", busy, 1);
    chk("R4 no early valid", outValid, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R4 valid due", outValid, 1);
    chk("R3 R6 R7 R10 result", outData, expOut);
    chk("R2 busy done", busy, 0);
    prevOut = outData;
    @(posedge clk);
    @(negedge clk);
    chk("R4 valid one cycle", outValid, 0);
    chk("R9 output held", outData, prevOut);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!doneFlag) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < NumTaps; k++) begin
      hist[k]    = '0;
      coefRom[k] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    chk("R1 busy reset", busy, 0);
    chk("R1 outValid reset", outValid, 0);
    chk("R1 overrun reset", overrun, 0);
    chk("R1 outData reset", outData, 0);

    // R1 R3: random coefficients over a fresh ring of zeros
    for (int k = 0; k < NumTaps; k++) coefRom[k] = DataW'($urandom_range(0, 8191)) - 16'sd4096;
    sendSample(16'sd20000, 1'b0);

    // R6: exact halves round up
    for (int k = 0; k < NumTaps; k++) coefRom[k] = '0;
    coefRom[0] = 16'sd16384;
    sendSample(16'sd1, 1'b0);
    sendSample(-16'sd1, 1'b0);
    sendSample(16'sd3, 1'b0);
    sendSample(-16'sd3, 1'b0);

    // R7: positive and negative saturation
    for (int k = 0; k < NumTaps; k++) coefRom[k] = 16'sd32767;
    for (int i = 0; i < NumTaps; i++) sendSample(16'sd32767, 1'b0);
    for (int i = 0; i < NumTaps; i++) sendSample(-16'sd32768, 1'b0);
    for (int k = 0; k < NumTaps; k++) coefRom[k] = -16'sd32768;
    sendSample(-16'sd32768, 1'b0);

    // R8 R10: random stream longer than the ring, with dropped samples
    for (int k = 0; k < NumTaps; k++) coefRom[k] = DataW'($urandom_range(0, 8191)) - 16'sd4096;
    for (int i = 0; i < 3 * NumTaps; i++)
      sendSample(DataW'($urandom), (i % 5) == 2);

    doneFlag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule